// File: doc/BRIEF.md
# Flyby DMA Channel Sequencer

This block runs one DMA channel. It moves a block of items between an I/O device that raises a request and an addressed device, which may be memory or a second I/O device. The channel works in one of two modes. In a direct (flyby) transfer, each item uses one bus cycle. The channel drives only its current address and strobes an acknowledge to the requesting device, so the data never enters the channel. In an indirect transfer, each item is a read from a source address into a holding register, followed by a write of that register to a destination address. Indirect mode covers copies where flyby is not possible: memory to memory, mismatched widths, or a target without flyby support.

Software loads the settings and pulses `start` while the channel is idle. The settings are direction, item size (8 or 16 bits), address stepping (frozen, up or down), bus policy, mode, item count and the two start addresses. The channel then asks for the bus and paces each item by the device request. Under the intermittent policy it gives the bus back after every item. Under the continuous policy it keeps the bus until the last item has moved. When the count runs out, the channel sets `done` and goes idle.

Top module: `flyby_dma_chan`

## Requirements
- R1: While reset is asserted and after it, `bus_req`, `bus_rd`, `bus_wr`, `dev_ack`, `busy` and `done` are all low.
- R2: A start with `cfg_count` equal to zero moves no item. In the cycle after the start, `done` is 1 and `busy` is 0, and no bus request or bus cycle follows.
- R3: A direct data phase lasts one cycle. In that cycle `dev_ack` is 1 and `bus_addr` is the primary address counter. `bus_rd` is 1 when `cfg_dir` is 0 (addressed device is read) and `bus_wr` is 1 when `cfg_dir` is 1 (addressed device is written). `bus_wdata` is 0 because no data passes through the channel.
- R4: Each indirect item is a read cycle at the primary counter, then in the next cycle a write cycle at the secondary counter. The write carries the data sampled on `bus_rdata` during the read. `dev_ack` stays 0 throughout.
- R5: After each item, both address counters change by the step, modulo 2^ADDR_W. The step is 1 for 8-bit items and 2 for 16-bit items. With `cfg_step_en` at 0 the counters stay frozen. With `cfg_step_en` at 1, `cfg_step_down` at 0 counts up and at 1 counts down.
- R6: During every data phase, `bus_wide` equals the item size that was latched at start (1 = 16-bit).
- R7: The item counter drops by one per item. After the item that brings it to zero, `done` is 1 and `busy` and `bus_req` are 0 in the next cycle. A new start clears `done`.
- R8: Under the intermittent policy (`cfg_cont` = 0), `bus_req` is low in the cycle after each item. With request and grant always present, a block of N direct items sets `done` 3N cycles after the start edge, and a block of N indirect items sets it 4N cycles after.
- R9: Under the continuous policy (`cfg_cont` = 1), `bus_req` stays high from its first assertion until the block ends. With request and grant always present, N direct items set `done` N+2 cycles after the start edge, and N indirect items set it 2N+2 cycles after.
- R10: No bus cycle and no acknowledge happen without `bus_grant`. `dev_req` is acted on only while the grant is held. Without `dev_req`, the channel does not request the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load settings and begin a block (taken only when idle) |
| cfg_dir | input | 1 | Direct mode: 0 reads the addressed device, 1 writes it |
| cfg_wide | input | 1 | Item size: 0 = 8-bit, 1 = 16-bit |
| cfg_step_en | input | 1 | Enable address stepping after each item |
| cfg_step_down | input | 1 | Step direction: 0 up, 1 down |
| cfg_cont | input | 1 | Bus policy: 0 intermittent, 1 continuous |
| cfg_indirect | input | 1 | Mode: 0 direct flyby, 1 indirect read-then-write |
| cfg_count | input | CNT_W | Number of items in the block |
| cfg_addr_a | input | ADDR_W | Start of the primary address counter |
| cfg_addr_b | input | ADDR_W | Start of the secondary (indirect destination) counter |
| dev_req | input | 1 | Request from the implied I/O device |
| dev_ack | output | 1 | Acknowledge to the implied I/O device during a direct data phase |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_wide | output | 1 | 16-bit item in this cycle |
| bus_wdata | output | DATA_W | Write data (indirect writes only, else 0) |
| bus_rdata | input | DATA_W | Read data |
| busy | output | 1 | A block is in progress |
| done | output | 1 | The last block has finished |

## Verification
The bench sweeps every combination of direction, size, stepping mode, bus policy and transfer mode, for block lengths of one and three items. It predicts each bus address arithmetically, starting the counters next to zero and at the top of the range, so that a counter that does not wrap, or that ignores the size when choosing its step, produces a wrong address. It checks the cycle at which `done` rises under each policy. A channel that holds the bus in intermittent mode, or inserts idle cycles in continuous mode, misses that cycle. Separate cases start a zero-length block, withhold the grant and drop the device request. A design that moves an item anyway, acknowledges during indirect cycles, or writes data other than the value just read is reported.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ARMED  = 3'd1,
      ST_REQ    = 3'd2,
      ST_DIRECT = 3'd3,
      ST_IND_RD = 3'd4,
      ST_IND_WR = 3'd5
   } seq_state_t;

   typedef struct packed {
      logic dir;
      logic wide;
      logic step_en;
      logic step_down;
      logic cont;
      logic indirect;
   } chan_cfg_t;

endpackage

// File: rtl/flyby_dma_addr_ctr.sv
module flyby_dma_addr_ctr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              advance,
   input  logic              step_en,
   input  logic              step_down,
   input  logic              wide,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] step;

   assign step = wide ? ADDR_W'(2) : ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (advance && step_en) begin
         addr <= step_down ? (addr - step) : (addr + step);
      end
   end

   // R5: a stepping item moves the counter by exactly one item size
   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && step_en && !load) |=>
         (((addr - $past(addr)) == $past(step)) || (($past(addr) - addr) == $past(step))));

   // R5: with stepping off the counter holds across an item
   assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !step_en && !load) |=> $stable(addr));

endmodule

// File: rtl/flyby_dma_blk_ctr.sv
module flyby_dma_blk_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last_item
);

   logic [CNT_W-1:0] remain;
   logic             empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (dec) begin
         remain <= remain - CNT_W'(1);
      end
   end

   assign last_item = (remain == CNT_W'(1));
   assign empty     = (remain == '0);

   // R7: an item is never counted against an exhausted block
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !empty);

endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
   import flyby_dma_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  chan_cfg_t cfg_in,
   input  logic      load_zero,
   input  logic      last_item,
   input  logic      dev_req,
   input  logic      bus_gnt,
   output chan_cfg_t cfg_q,
   output logic      load,
   output logic      item_done,
   output logic      hold_en,
   output logic      sel_dst,
   output logic      bus_req,
   output logic      dev_ack,
   output logic      bus_rd,
   output logic      bus_wr,
   output logic      busy,
   output logic      done
);

   seq_state_t st, st_nxt, st_after;
   seq_state_t st_xfer;

   assign load    = (st == ST_IDLE) && start;
   assign st_xfer = cfg_q.indirect ? ST_IND_RD : ST_DIRECT;

   always_comb begin
      if (last_item) begin
         st_after = ST_IDLE;
      end else if (!cfg_q.cont) begin
         st_after = ST_ARMED;
      end else if (dev_req && bus_gnt) begin
         st_after = st_xfer;
      end else begin
         st_after = ST_REQ;
      end
   end

   always_comb begin
      st_nxt    = st;
      item_done = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start) st_nxt = load_zero ? ST_IDLE : ST_ARMED;
         end
         ST_ARMED: begin
            if (dev_req) st_nxt = ST_REQ;
         end
         ST_REQ: begin
            if (bus_gnt && dev_req) st_nxt = st_xfer;
         end
         ST_DIRECT: begin
            item_done = 1'b1;
            st_nxt    = st_after;
         end
         ST_IND_RD: begin
            st_nxt = ST_IND_WR;
         end
         ST_IND_WR: begin
            item_done = 1'b1;
            st_nxt    = st_after;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cfg_q <= '0;
         done  <= 1'b0;
      end else begin
         st <= st_nxt;
         if (load) begin
            cfg_q <= cfg_in;
            done  <= load_zero;
         end else if (item_done && last_item) begin
            done <= 1'b1;
         end
      end
   end

   assign bus_req = (st == ST_REQ) || (st == ST_DIRECT) || (st == ST_IND_RD) || (st == ST_IND_WR);
   assign dev_ack = (st == ST_DIRECT);
   assign bus_rd  = ((st == ST_DIRECT) && !cfg_q.dir) || (st == ST_IND_RD);
   assign bus_wr  = ((st == ST_DIRECT) && cfg_q.dir) || (st == ST_IND_WR);
   assign hold_en = (st == ST_IND_RD);
   assign sel_dst = (st == ST_IND_WR);
   assign busy    = (st != ST_IDLE);

   // R3: the acknowledge only accompanies a granted single-strobe bus cycle
   assert_ack_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (bus_gnt && (bus_rd != bus_wr)));

   // R10: no bus cycle runs without mastership
   assert_no_cycle_ungranted_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> bus_gnt);

   // R4: an indirect write is always preceded by its read
   assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_dst |-> ($past(hold_en) && !dev_ack));

   // R9: continuous policy keeps the bus between items
   assert_cont_keeps_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (item_done && cfg_q.cont && !last_item) |=> bus_req);

   // R8: intermittent policy hands the bus back after every item
   assert_int_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (item_done && !cfg_q.cont) |=> !bus_req);

   // R7: completion leaves the channel idle and off the bus
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !bus_req));

endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
   import flyby_dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_dir,
   input  logic              cfg_wide,
   input  logic              cfg_step_en,
   input  logic              cfg_step_down,
   input  logic              cfg_cont,
   input  logic              cfg_indirect,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [ADDR_W-1:0] cfg_addr_a,
   input  logic [ADDR_W-1:0] cfg_addr_b,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_wide,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              done
);

   localparam int NUM_PTR = 2;

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("flyby_dma_chan: ADDR_W below 2 cannot hold a 16-bit step");
      end
      if (DATA_W < 16) begin : g_bad_data_w
         $error("flyby_dma_chan: DATA_W must carry a 16-bit item");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("flyby_dma_chan: CNT_W must be positive");
      end
   endgenerate

   chan_cfg_t cfg_in, cfg_q;
   logic      load, item_done, hold_en, sel_dst, last_item;
   logic      load_zero;
   logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_init, ptr_q;
   logic [DATA_W-1:0] hold_q;

   assign cfg_in = '{dir: cfg_dir, wide: cfg_wide, step_en: cfg_step_en,
                     step_down: cfg_step_down, cont: cfg_cont, indirect: cfg_indirect};
   assign load_zero   = (cfg_count == '0);
   assign ptr_init[0] = cfg_addr_a;
   assign ptr_init[1] = cfg_addr_b;

   flyby_dma_seq seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_in    (cfg_in),
      .load_zero (load_zero),
      .last_item (last_item),
      .dev_req   (dev_req),
      .bus_gnt   (bus_gnt),
      .cfg_q     (cfg_q),
      .load      (load),
      .item_done (item_done),
      .hold_en   (hold_en),
      .sel_dst   (sel_dst),
      .bus_req   (bus_req),
      .dev_ack   (dev_ack),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .busy      (busy),
      .done      (done)
   );

   flyby_dma_blk_ctr #(.CNT_W(CNT_W)) blk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (cfg_count),
      .dec       (item_done),
      .last_item (last_item)
   );

   for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
      flyby_dma_addr_ctr #(.ADDR_W(ADDR_W)) ptr_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .load_val  (ptr_init[gi]),
         .advance   (item_done),
         .step_en   (cfg_q.step_en),
         .step_down (cfg_q.step_down),
         .wide      (cfg_q.wide),
         .addr      (ptr_q[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (hold_en) begin
         hold_q <= bus_rdata;
      end
   end

   assign bus_addr  = sel_dst ? ptr_q[1] : ptr_q[0];
   assign bus_wdata = sel_dst ? hold_q : '0;
   assign bus_wide  = cfg_q.wide;

   // R3: flyby cycles never put data from the channel on the bus
   assert_flyby_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> (bus_wdata == '0));

   // R4: the indirect write repeats the word sampled in the read before it
   assert_copy_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !dev_ack) |-> (bus_wdata == $past(bus_rdata)));

endmodule

// File: tb/flyby_dma_chan_tb.sv
module flyby_dma_chan_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 8;
   localparam logic [DW-1:0] RD_MASK = 16'hC3A5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cfg_dir = 1'b0, cfg_wide = 1'b0, cfg_step_en = 1'b0, cfg_step_down = 1'b0;
   logic cfg_cont = 1'b0, cfg_indirect = 1'b0;
   logic [CW-1:0] cfg_count = '0;
   logic [AW-1:0] cfg_addr_a = '0, cfg_addr_b = '0;
   logic dev_req = 1'b0;
   logic gnt_en = 1'b1;
   logic dev_ack, bus_req, bus_gnt, bus_rd, bus_wr, bus_wide, busy, done;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign bus_gnt   = bus_req & gnt_en;
   assign bus_rdata = bus_addr ^ RD_MASK;

   flyby_dma_chan #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_dir(cfg_dir), .cfg_wide(cfg_wide), .cfg_step_en(cfg_step_en),
      .cfg_step_down(cfg_step_down), .cfg_cont(cfg_cont), .cfg_indirect(cfg_indirect),
      .cfg_count(cfg_count), .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
      .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input bit wide,
                                               input bit sen, input bit sdown);
      logic [AW-1:0] st;
      st = wide ? AW'(2) : AW'(1);
      if (!sen) return a;
      return sdown ? a - st : a + st;
   endfunction

   task automatic kick(input bit dir, input bit wide, input bit sen, input bit sdown,
                       input bit cont, input bit ind, input int n,
                       input logic [AW-1:0] a0, input logic [AW-1:0] b0);
      cfg_dir = dir; cfg_wide = wide; cfg_step_en = sen; cfg_step_down = sdown;
      cfg_cont = cont; cfg_indirect = ind; cfg_count = CW'(n);
      cfg_addr_a = a0; cfg_addr_b = b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Runs one block with request and grant always present; t counts edges after the start edge.
   task automatic run_case(input bit dir, input bit wide, input bit sen, input bit sdown,
                           input bit cont, input bit ind, input int n,
                           input logic [AW-1:0] a0, input logic [AW-1:0] b0);
      logic [AW-1:0] ea, eb;
      logic [DW-1:0] exp_data;
      int t, items, exp_t;
      bit prev_item;
      ea = a0; eb = b0; exp_data = '0; items = 0; prev_item = 0;
      dev_req = 1'b1; gnt_en = 1'b1;
      kick(dir, wide, sen, sdown, cont, ind, n, a0, b0);
      t = 0;
      chk(done == 1'b0 && busy == 1'b1, "R7", "start clears done", done, 0);
      forever begin
         if (done || t > 60) break;
         if (cont && t >= 1)
            chk(bus_req == 1'b1, "R9", "bus held in continuous", bus_req, 1);
         if (!cont && prev_item)
            chk(bus_req == 1'b0, "R8", "bus released after item", bus_req, 0);
         prev_item = 0;
         if (dev_ack) begin
            chk(!ind, "R3", "ack only in direct mode", ind, 0);
            chk(bus_rd == !dir && bus_wr == dir, "R3", "strobe follows direction",
                {bus_rd, bus_wr}, {!dir, dir});
            chk(bus_addr == ea, "R5", "direct address", bus_addr, ea);
            chk(bus_wdata == '0, "R3", "no data through channel", bus_wdata, 0);
            chk(bus_wide == wide, "R6", "item size", bus_wide, wide);
            ea = next_addr(ea, wide, sen, sdown);
            items++; prev_item = 1;
         end else if (bus_rd) begin
            chk(ind, "R4", "read without ack in indirect", ind, 1);
            chk(bus_addr == ea, "R5", "source address", bus_addr, ea);
            chk(bus_wide == wide, "R6", "item size", bus_wide, wide);
            exp_data = ea ^ RD_MASK;
         end else if (bus_wr) begin
            chk(ind, "R4", "write without ack in indirect", ind, 1);
            chk(bus_addr == eb, "R5", "destination address", bus_addr, eb);
            chk(bus_wdata == exp_data, "R4", "copied data", bus_wdata, exp_data);
            ea = next_addr(ea, wide, sen, sdown);
            eb = next_addr(eb, wide, sen, sdown);
            items++; prev_item = 1;
         end
         @(negedge clk);
         t++;
      end
      if (ind) exp_t = cont ? 2*n + 2 : 4*n;
      else     exp_t = cont ? n + 2 : 3*n;
      chk(t == exp_t, cont ? "R9" : "R8", "cycles to done", t, exp_t);
      chk(items == n, "R7", "items moved", items, n);
      chk(busy == 1'b0 && bus_req == 1'b0, "R7", "idle after block", {busy, bus_req}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({bus_req, bus_rd, bus_wr, dev_ack, busy, done} == 6'b0, "R1", "outputs in reset",
          {bus_req, bus_rd, bus_wr, dev_ack, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({bus_req, bus_rd, bus_wr, dev_ack, busy, done} == 6'b0, "R1", "outputs after reset",
          {bus_req, bus_rd, bus_wr, dev_ack, busy, done}, 0);

      // R2: zero-length block
      dev_req = 1'b1;
      kick(0, 0, 1, 0, 1, 0, 0, 16'h0010, 16'h0020);
      chk(done == 1'b1 && busy == 1'b0, "R2", "zero count completes at once", {done, busy}, 2'b10);
      for (int k = 0; k < 5; k++) begin
         chk(!bus_req && !bus_rd && !bus_wr && !dev_ack, "R2", "no bus activity",
             {bus_req, bus_rd, bus_wr, dev_ack}, 0);
         @(negedge clk);
      end

      // Full sweep of settings for lengths 1 and 3 (R3..R9)
      for (int m = 0; m < 96; m++) begin
         int n;
         bit sen, sdown;
         n = (m[0]) ? 3 : 1;
         sen   = (m[3:2] != 2'd0);
         sdown = (m[3:2] == 2'd2);
         if (m[3:2] == 2'd3) continue;
         run_case(m[6], m[1], sen, sdown, m[4], m[5], n, 16'h0001, 16'hFFFF);
         @(negedge clk);
      end
      for (int m = 0; m < 32; m++) begin
         run_case(m[0], m[1], 1'b1, m[2], m[3], m[4], 3, 16'hFFFE, 16'h0000);
         @(negedge clk);
      end

      // R10: request without grant, then grant without request
      dev_req = 1'b1; gnt_en = 1'b0;
      kick(0, 1, 1, 0, 1, 0, 2, 16'h0100, 16'h0000);
      for (int k = 0; k < 6; k++) begin
         chk(!bus_rd && !bus_wr && !dev_ack, "R10", "no cycle without grant",
             {bus_rd, bus_wr, dev_ack}, 0);
         if (k >= 1) chk(bus_req == 1'b1, "R10", "request kept while waiting", bus_req, 1);
         @(negedge clk);
      end
      gnt_en = 1'b1;
      @(negedge clk);
      chk(dev_ack && bus_addr == 16'h0100, "R10", "first item after grant", bus_addr, 16'h0100);
      @(negedge clk);
      chk(dev_ack && bus_addr == 16'h0102, "R10", "second item follows", bus_addr, 16'h0102);
      @(negedge clk);
      chk(done == 1'b1, "R10", "block ends after grant", done, 1);

      dev_req = 1'b0;
      kick(1, 0, 0, 0, 0, 0, 1, 16'h0200, 16'h0000);
      for (int k = 0; k < 5; k++) begin
         chk(!bus_req && !dev_ack && busy, "R10", "idle without device request",
             {bus_req, dev_ack, busy}, 3'b001);
         @(negedge clk);
      end
      dev_req = 1'b1;
      @(negedge clk);
      chk(bus_req && !dev_ack, "R10", "request after device asks", {bus_req, dev_ack}, 2'b10);
      @(negedge clk);
      chk(dev_ack && bus_wr && bus_addr == 16'h0200, "R10", "write item at frozen address",
          bus_addr, 16'h0200);
      @(negedge clk);
      chk(done == 1'b1, "R7", "done after single item", done, 1);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule